// File: doc/BRIEF.md
# Fractional-Capable 8x8 Multiply Unit

This block multiplies two 8-bit operands and places the 16-bit outcome in a dedicated high/low result register pair, never in the operand sources. A three-bit mode selects how each operand is interpreted. Both can be unsigned, both can be two's complement, or the first can be signed while the second is unsigned. A separate mode bit picks fractional form, in which the product is moved up by one bit position. This is the form needed when 8-bit operands stand for fixed-point fractions with one sign or integer bit.

A caller raises `start_i` for one cycle with the operands and mode. The unit takes these values at that edge and raises `busy_o` for one cycle. At the second edge it writes the result pair and the two flags, and pulses `done_o`. Only the zero and carry flags are produced. Carry is always the top bit of the product before the fractional shift. Operand fetch and instruction decode belong to the surrounding core.

Top module: `fmul_unit`

## Requirements
- R1: While reset is active, and after it is released until the first operation completes, `busy_o`, `done_o`, `zero_o`, `carry_o`, `res_hi_o` and `res_lo_o` are all 0.
- R2: A `start_i` sampled high while `busy_o` is low is accepted. `busy_o` is then high for exactly one cycle. `done_o` is high for exactly one cycle, which follows the second rising edge after the accepting edge. The result pair and flags change at that same edge.
- R3: A `start_i` sampled while `busy_o` is high is ignored. No extra `done_o` pulse follows it, and the result pair and flags keep the earlier operation's values.
- R4: `mode_i[1:0]` sets signedness: 00 means both unsigned, 01 means both signed, 10 means `opa_i` signed and `opb_i` unsigned, and 11 behaves exactly like 00. `mode_i[2]`=1 selects fractional form.
- R5: In unsigned integer mode, {`res_hi_o`,`res_lo_o`} equals the unsigned product of the operands.
- R6: In signed integer mode, the result pair holds the 16-bit two's complement product of the operands.
- R7: In mixed integer mode (10), the result pair holds the 16-bit two's complement product of signed `opa_i` and unsigned `opb_i`.
- R8: In fractional mode, the result pair is the integer-mode product shifted left by one. Bit 0 becomes 0 and the pre-shift bit 15 is dropped.
- R9: `carry_o` equals bit 15 of the product before any fractional shift, in every mode.
- R10: `zero_o` is 1 exactly when the final 16-bit result written to the pair is zero.
- R11: Operand and mode values are captured at the accepting edge, so later changes on the inputs do not affect that result. The result pair and flags hold steady in every cycle that is not a completion.
- R12: A `start_i` presented in the same cycle as `done_o` is accepted. Its result follows two edges later, and the completing result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a multiply |
| mode_i | input | 3 | [2] fractional, [1:0] signedness select |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| res_hi_o | output | 8 | Result register, upper byte |
| res_lo_o | output | 8 | Result register, lower byte |
| zero_o | output | 1 | Final result is zero |
| carry_o | output | 1 | Bit 15 of the unshifted product |

## Verification
Two things can land in one cycle: a completion that writes the result pair, and either a fresh request or one that arrives too early. The bench holds `start_i` high through the busy cycle and changes the operands there. It then confirms that only one completion appears and that the pair still carries the first product. In a second scenario a new request is raised in the cycle where `done_o` is high. The bench confirms that the completing value is intact in that cycle, and that the new product arrives exactly two edges later.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_ALT = 2'b11
  } sign_sel_e;

  typedef struct packed {
    logic      frac;
    sign_sel_e sel;
  } mul_mode_t;

  // bit 0: first operand signed, bit 1: second operand signed
  function automatic logic [1:0] operand_signed(sign_sel_e s);
    logic [1:0] r;
    case (s)
      SGN_SS:  r = 2'b11;
      SGN_SU:  r = 2'b01;
      default: r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fmul_rst_sync.sv
module fmul_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/fmul_ctrl.sv
module fmul_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, busy_d;
  logic done_q, done_d;

  always_comb begin
    accept_o = start_i & ~busy_q;
    busy_d   = accept_o;
    done_d   = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R2: an accepted request occupies exactly one busy cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R2: busy is followed by the completion pulse
  p_busy_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (done_o && !busy_o));
  // R3: a request during busy starts nothing, so busy never lasts two cycles
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);
  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/fmul_datapath.sv
module fmul_datapath
  import fmul_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  mul_mode_t       mode,
  output logic [2*DW-1:0] result,
  output logic            carry,
  output logic            zero
);
  localparam int PW = 2 * DW;

  logic [1:0]           sgn;
  logic [1:0][DW-1:0]   ops;
  logic [1:0][PW-1:0]   ext;
  logic [PW-1:0]        raw;

  assign sgn = operand_signed(mode.sel);
  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    assign ext[g] = {{DW{sgn[g] & ops[g][DW-1]}}, ops[g]};
  end

  always_comb begin
    raw    = ext[0] * ext[1];
    carry  = raw[PW-1];
    result = mode.frac ? {raw[PW-2:0], 1'b0} : raw;
    zero   = (result == '0);
  end
endmodule

// File: rtl/fmul_unit.sv
module fmul_unit
  import fmul_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] res_hi_o,
  output logic [DW-1:0] res_lo_o,
  output logic          zero_o,
  output logic          carry_o
);
  localparam int PW = 2 * DW;

  logic rst_n;
  logic accept;
  logic busy;

  logic [DW-1:0] opa_q, opa_d;
  logic [DW-1:0] opb_q, opb_d;
  mul_mode_t     mode_q, mode_d;

  logic [PW-1:0] res_q, res_d, dp_res;
  logic          z_q, z_d, dp_z;
  logic          c_q, c_d, dp_c;

  fmul_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  fmul_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  fmul_datapath #(.DW(DW)) u_dp (
    .op_a   (opa_q),
    .op_b   (opb_q),
    .mode   (mode_q),
    .result (dp_res),
    .carry  (dp_c),
    .zero   (dp_z)
  );

  // next state: operand capture enabled by accept, result write by busy
  always_comb begin
    opa_d  = accept ? opa_i : opa_q;
    opb_d  = accept ? opb_i : opb_q;
    mode_d = accept ? mul_mode_t'(mode_i) : mode_q;
    res_d  = busy ? dp_res : res_q;
    z_d    = busy ? dp_z   : z_q;
    c_d    = busy ? dp_c   : c_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      mode_q <= '0;
      res_q  <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
    end else begin
      opa_q  <= opa_d;
      opb_q  <= opb_d;
      mode_q <= mode_d;
      res_q  <= res_d;
      z_q    <= z_d;
      c_q    <= c_d;
    end
  end

  assign busy_o   = busy;
  assign res_hi_o = res_q[PW-1:DW];
  assign res_lo_o = res_q[DW-1:0];
  assign zero_o   = z_q;
  assign carry_o  = c_q;

  // R11: outside a completing edge the result pair and flags hold
  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(res_q) && $stable(zero_o) && $stable(carry_o)));
  // R11: captured operands stay put while the operation is in flight
  p_operands_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(opa_q) && $stable(opb_q) && $stable(mode_q)));
  // R8: a fractional result always has a cleared least significant bit
  p_frac_lsb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q.frac) |-> (res_lo_o[0] == 1'b0));
  // R10: the zero flag agrees with the delivered pair
  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (zero_o == ({res_hi_o, res_lo_o} == '0)));
endmodule

// File: tb/fmul_unit_test.sv
module fmul_unit_test;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       start_i;
  logic [2:0] mode_i;
  logic [7:0] opa_i, opb_i;
  logic       busy_o, done_o, zero_o, carry_o;
  logic [7:0] res_hi_o, res_lo_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fmul_unit uut (
    .clk(clk), .arst_n(arst_n), .start_i(start_i), .mode_i(mode_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  // independent reference: returns {zero, carry, result}
  function automatic logic [17:0] model(logic [7:0] a, logic [7:0] b, logic [2:0] m);
    logic signed [31:0] ia, ib, p;
    logic [15:0] raw, res;
    ia = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? {{24{a[7]}}, a} : {24'b0, a};
    ib = (m[1:0] == 2'b01) ? {{24{b[7]}}, b} : {24'b0, b};
    p = ia * ib;
    raw = p[15:0];
    res = m[2] ? {raw[14:0], 1'b0} : raw;
    return {(res == 16'h0), raw[15], res};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_result(string tag, logic [17:0] exp);
    chk(tag, {14'b0, zero_o, carry_o, res_hi_o, res_lo_o}, {14'b0, exp});
  endtask

  task automatic issue(logic [7:0] a, logic [7:0] b, logic [2:0] m);
    start_i = 1'b1; opa_i = a; opb_i = b; mode_i = m;
  endtask

  // ends at the falling edge inside the done cycle
  task automatic do_op(string tag, logic [7:0] a, logic [7:0] b, logic [2:0] m);
    @(negedge clk);
    issue(a, b, m);
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R2 busy"}, {30'b0, busy_o, done_o}, 32'b10);
    @(negedge clk);
    chk({tag, " R2 done"}, {30'b0, busy_o, done_o}, 32'b01);
    chk_result(tag, model(a, b, m));
  endtask

  task automatic t_reset;
    arst_n = 1'b0; start_i = 1'b0; mode_i = 3'b0; opa_i = 8'h0; opb_i = 8'h0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {26'b0, busy_o, done_o, zero_o, carry_o, |res_hi_o, |res_lo_o}, 32'b0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {26'b0, busy_o, done_o, zero_o, carry_o, |res_hi_o, |res_lo_o}, 32'b0);
  endtask

  task automatic t_integer;
    do_op("R5 uu ff*ff", 8'hFF, 8'hFF, 3'b000);
    do_op("R5 uu 12*34", 8'h12, 8'h34, 3'b000);
    do_op("R6 ss ff*ff", 8'hFF, 8'hFF, 3'b001);
    do_op("R6 ss 80*7f", 8'h80, 8'h7F, 3'b001);
    do_op("R7 su ff*ff", 8'hFF, 8'hFF, 3'b010);
    do_op("R7 su 80*80", 8'h80, 8'h80, 3'b010);
    do_op("R4 alt ff*ff", 8'hFF, 8'hFF, 3'b011);
  endtask

  task automatic t_fraction;
    do_op("R8 R9 fuu ff*ff", 8'hFF, 8'hFF, 3'b100);
    do_op("R8 R9 fss 80*80", 8'h80, 8'h80, 3'b101);
    do_op("R8 R9 fss c0*40", 8'hC0, 8'h40, 3'b101);
    do_op("R8 fsu 80*ff", 8'h80, 8'hFF, 3'b110);
    do_op("R10 zero int", 8'h00, 8'h9A, 3'b001);
    do_op("R10 zero frac", 8'h5C, 8'h00, 3'b110);
  endtask

  // R3: start held through the busy cycle with new operands
  task automatic t_busy_ignore;
    @(negedge clk);
    issue(8'h0F, 8'h11, 3'b000);
    @(negedge clk);
    issue(8'hA5, 8'h3C, 3'b001);
    chk("R3 busy", {31'b0, busy_o}, 32'b1);
    @(negedge clk);
    start_i = 1'b0;
    chk("R3 done", {31'b0, done_o}, 32'b1);
    chk_result("R3 first result", model(8'h0F, 8'h11, 3'b000));
    @(negedge clk);
    chk("R3 no second done", {30'b0, busy_o, done_o}, 32'b0);
    chk_result("R3 result kept", model(8'h0F, 8'h11, 3'b000));
  endtask

  // R11: operands change after acceptance; outputs hold while idle
  task automatic t_capture_hold;
    @(negedge clk);
    issue(8'h7F, 8'h7F, 3'b101);
    @(negedge clk);
    start_i = 1'b0; opa_i = 8'h00; opb_i = 8'h00; mode_i = 3'b000;
    @(negedge clk);
    chk_result("R11 captured", model(8'h7F, 8'h7F, 3'b101));
    repeat (3) @(negedge clk);
    chk_result("R11 held idle", model(8'h7F, 8'h7F, 3'b101));
  endtask

  // R12: new request raised in the done cycle
  task automatic t_back_to_back;
    do_op("R12 first", 8'h23, 8'h45, 3'b000);
    issue(8'hFE, 8'h03, 3'b010);
    chk_result("R12 completing intact", model(8'h23, 8'h45, 3'b000));
    @(negedge clk);
    start_i = 1'b0;
    chk("R12 accepted", {30'b0, busy_o, done_o}, 32'b10);
    chk_result("R12 held while busy", model(8'h23, 8'h45, 3'b000));
    @(negedge clk);
    chk("R12 second done", {31'b0, done_o}, 32'b1);
    chk_result("R12 second result", model(8'hFE, 8'h03, 3'b010));
  endtask

  initial begin
    t_reset;
    t_integer;
    t_fraction;
    t_busy_ignore;
    t_capture_hold;
    t_back_to_back;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule